// File: doc/BRIEF.md
# Byte-Lane Splitting Bus Bridge

This bridge connects a requester that issues byte or 16-bit reads and writes to a memory port that moves only 8 data bits per cycle. Addresses on both sides count bytes. A byte request becomes one memory cycle. A 16-bit request becomes two memory cycles at consecutive addresses, and the order is fixed: the low byte goes first, at the request address, and the high byte goes second, at that address plus one. A 16-bit write of 0x1234 to address A therefore stores 0x34 at A and 0x12 at A+1.

The bridge takes a request only while it is idle. It copies the address, size, direction and write data at that moment, so the requester may change its outputs while the transfer runs. Each memory cycle holds its address, data and write strobe steady until the memory acknowledges it, so the memory may insert any number of wait states. When the last byte has been acknowledged, the bridge raises ready for one cycle. For reads, ready comes with the assembled data.

Top module: `bnb_bridge`

## Requirements
- R1: Once a synchronous active-low reset has been applied, `cpu_ready` and `mem_req` are low and no memory cycle starts until `cpu_valid` is seen.
- R2: A request with `cpu_size`=1 (16-bit) produces exactly two memory cycles: the first at `cpu_addr`, the second at `cpu_addr`+1.
- R3: In a 16-bit write, the first memory cycle carries `cpu_wdata[7:0]` and the second carries `cpu_wdata[15:8]`, both with `mem_we`=1.
- R4: The second address of a 16-bit access wraps modulo 2^ADDR_W, so a 16-bit access at the all-ones address places its second byte at address 0.
- R5: A request with `cpu_size`=0 (byte) produces exactly one memory cycle at `cpu_addr`. A byte write carries `cpu_wdata[7:0]`, and `cpu_wdata[15:8]` has no effect on memory.
- R6: A 16-bit read returns the first fetched byte in `cpu_rdata[7:0]` and the second in `cpu_rdata[15:8]`.
- R7: A byte read returns the fetched byte in `cpu_rdata[7:0]`, with `cpu_rdata[15:8]` equal to zero.
- R8: `cpu_ready` stays low until the last memory acknowledge of a request. It goes high in the cycle after that acknowledge, for exactly one cycle.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_wdata` and `mem_we` hold their values, for any number of wait cycles.
- R10: The request fields are sampled only when the bridge accepts a request while idle. Changes to `cpu_addr`, `cpu_size`, `cpu_write` or `cpu_wdata` during a transfer have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Request present; held until cpu_ready |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 1 | 0 = byte, 1 = 16-bit |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 16 | Write data, low byte in bits 7:0 |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory cycle in progress |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | ADDR_W | Byte address of the current cycle |
| mem_wdata | output | 8 | Byte written in the current cycle |
| mem_rdata | input | 8 | Byte returned by memory, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the current cycle |

## Verification
The hardest case to reach is a 16-bit access at the all-ones address. Its second cycle must wrap to address 0, and that has to hold while the memory is inserting wait states and the requester is changing its outputs in the middle of the transfer. The bench sweeps every address of an 8-bit address space with 16-bit and byte writes and reads. Its memory responder inserts a wait count that depends on the address, and the requester drives different values onto its outputs after each acceptance. The top address is therefore reached under every combination, and the expected bytes are computed from the address.

// File: rtl/bnb_pkg.sv
// Shared types for the byte-lane splitting bridge.
// Assumes a 16-bit requester and an 8-bit memory port (two lanes).
package bnb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2,
        PH_DONE = 2'd3
    } phase_t;
endpackage

// File: rtl/bnb_ctrl.sv
// Sequencer for the bridge. Accepts a request only while idle, runs the low
// lane cycle, then the high lane cycle for 16-bit requests, and raises a
// one-cycle ready pulse afterwards. Assumes word_q is valid from the cycle
// after acceptance.
module bnb_ctrl
    import bnb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_valid,
    input  logic word_q,
    input  logic mem_ack,
    output logic take,
    output logic mem_req,
    output logic hi_lane,
    output logic cpu_ready
);
    phase_t ph;

    // Phase register: idle -> low lane -> (high lane) -> done -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_IDLE;
        end else begin
            case (ph)
                PH_IDLE: if (cpu_valid) ph <= PH_LO;
                PH_LO:   if (mem_ack) ph <= word_q ? PH_HI : PH_DONE;
                PH_HI:   if (mem_ack) ph <= PH_DONE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Decode of the phase into handshake and lane controls
    always_comb begin
        take      = (ph == PH_IDLE) && cpu_valid;
        mem_req   = (ph == PH_LO) || (ph == PH_HI);
        hi_lane   = (ph == PH_HI);
        cpu_ready = (ph == PH_DONE);
    end

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R8
    ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> $past(mem_req && mem_ack));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_IDLE && !cpu_valid) |=> !mem_req);
endmodule

// File: rtl/bnb_datapath.sv
// Datapath for the bridge. Captures the request fields on acceptance, steers
// the current lane's address and write byte to memory, and assembles read
// bytes into their lanes. Assumes lane 0 is the low byte and is moved first.
module bnb_datapath #(
    parameter int ADDR_W = 8,
    parameter int MEM_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic                 mem_req,
    input  logic                 hi_lane,
    input  logic                 mem_ack,
    input  logic                 cpu_write,
    input  logic                 cpu_size,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [2*MEM_W-1:0]   cpu_wdata,
    input  logic [MEM_W-1:0]     mem_rdata,
    output logic                 word_q,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [MEM_W-1:0]     mem_wdata,
    output logic [2*MEM_W-1:0]   cpu_rdata
);
    localparam int LANES = 2;

    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [MEM_W-1:0]  wd_q [LANES];
    logic [MEM_W-1:0]  rd_q [LANES];

    // Request capture: address, size and direction at acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            word_q  <= 1'b0;
        end else if (take) begin
            addr_q  <= cpu_addr;
            write_q <= cpu_write;
            word_q  <= cpu_size;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Write byte capture for this lane
        always_ff @(posedge clk) begin
            if (!rst_n) wd_q[g] <= '0;
            else if (take) wd_q[g] <= cpu_wdata[g*MEM_W +: MEM_W];
        end

        // Read byte capture for this lane; upper lanes clear on acceptance
        always_ff @(posedge clk) begin
            if (!rst_n) rd_q[g] <= '0;
            else if (mem_req && mem_ack && (hi_lane == (g != 0))) rd_q[g] <= mem_rdata;
            else if (take && g != 0) rd_q[g] <= '0;
        end

        assign cpu_rdata[g*MEM_W +: MEM_W] = rd_q[g];
    end

    // Lane steering toward memory; second address wraps at the top
    always_comb begin
        mem_addr  = addr_q + {{(ADDR_W-1){1'b0}}, hi_lane};
        mem_wdata = hi_lane ? wd_q[1] : wd_q[0];
        mem_we    = mem_req && write_q;
    end
endmodule

// File: rtl/bnb_bridge.sv
// Top of the byte-lane splitting bridge. A 16-bit request becomes two
// little-endian byte cycles (low lane first); a byte request becomes one.
// Assumes the requester holds cpu_valid until cpu_ready and the memory holds
// mem_rdata valid with mem_ack.
module bnb_bridge #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic              cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic [15:0]       cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack
);
    localparam int MEM_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic take;
    logic hi_lane;
    logic word_q;

    bnb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .word_q    (word_q),
        .mem_ack   (mem_ack),
        .take      (take),
        .mem_req   (mem_req),
        .hi_lane   (hi_lane),
        .cpu_ready (cpu_ready)
    );

    bnb_datapath #(.ADDR_W(ADDR_W), .MEM_W(MEM_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .mem_req   (mem_req),
        .hi_lane   (hi_lane),
        .mem_ack   (mem_ack),
        .cpu_write (cpu_write),
        .cpu_size  (cpu_size),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .mem_rdata (mem_rdata),
        .word_q    (word_q),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .cpu_rdata (cpu_rdata)
    );

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2 R4
    next_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !hi_lane && word_q) |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_ONE));

    // R5
    byte_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !hi_lane && !word_q) |=> !mem_req);
endmodule

// File: tb/bnb_bridge_tb.sv
module bnb_bridge_tb;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0, cpu_write = 1'b0, cpu_size = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [15:0]   cpu_wdata = '0;
    logic          cpu_ready;
    logic [15:0]   cpu_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          mem_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int wait_n = 0;
    int cyc = 0;

    logic [7:0]    mem [256];
    logic [AW-1:0] log_addr [4];
    logic          log_we [4];
    logic [7:0]    log_data [4];
    int            log_n = 0;

    bnb_bridge #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                finish_run();
            end
        end
    end

    // Memory responder: acknowledges after wait_n cycles and logs each cycle
    initial begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hC3;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (mem_req && rst_n) begin
                if (cnt >= wait_n) begin
                    if (log_n < 4) begin
                        log_addr[log_n] = mem_addr;
                        log_we[log_n]   = mem_we;
                        log_data[log_n] = mem_we ? mem_wdata : mem[mem_addr];
                    end
                    log_n++;
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    else mem_rdata = mem[mem_addr];
                    mem_ack = 1'b1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // One request: the payload is changed after acceptance (R10), then ready is awaited
    task automatic access(input bit wr, input bit sz, input logic [AW-1:0] a,
                          input logic [15:0] wd, input int wt, output logic [15:0] rd);
        int n_exp;
        int guard;
        n_exp = sz ? 2 : 1;
        wait_n = wt;
        @(negedge clk);
        log_n = 0;
        cpu_valid = 1'b1; cpu_write = wr; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_write = ~wr; cpu_size = ~sz; cpu_addr = ~a; cpu_wdata = ~wd;
        guard = 0;
        while (!cpu_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        // R8: ready not before the last acknowledge
        chk(cpu_ready && log_n == n_exp, "R8 ready after last ack", log_n, n_exp);
        rd = cpu_rdata;
        cpu_valid = 1'b0;
        @(negedge clk);
        // R8: single-cycle pulse
        chk(!cpu_ready, "R8 ready pulse width", int'(cpu_ready), 0);
        @(negedge clk);
        // R10/R5/R2: no extra cycles from the changed payload
        chk(log_n == n_exp && !mem_req, "R10 cycle count", log_n, n_exp);
    endtask

    initial begin
        logic [15:0]   rd;
        logic [AW-1:0] a1;
        logic [7:0]    lo, hi, bb, keep_next;
        repeat (3) @(negedge clk);
        // R1
        chk(!cpu_ready && !mem_req, "R1 reset state", int'({cpu_ready, mem_req}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mem_req && log_n == 0, "R1 no cycle while idle", log_n, 0);

        for (int a = 0; a < 256; a++) begin
            a1 = AW'(a + 1);
            lo = 8'(a) ^ 8'h5A;
            hi = ~8'(a) + 8'h11;
            // 16-bit write
            access(1'b1, 1'b1, AW'(a), {hi, lo}, a % 4, rd);
            chk(log_addr[0] == AW'(a) && log_addr[1] == a1, "R2 R4 word write addresses",
                int'({log_addr[0], log_addr[1]}), int'({AW'(a), a1}));
            chk(log_we[0] && log_we[1] && log_data[0] == lo && log_data[1] == hi,
                "R3 word write byte order", int'({log_data[0], log_data[1]}), int'({lo, hi}));
            // 16-bit read back
            access(1'b0, 1'b1, AW'(a), 16'h0, (a + 1) % 4, rd);
            chk(log_addr[0] == AW'(a) && log_addr[1] == a1 && !log_we[0] && !log_we[1],
                "R2 R4 word read addresses", int'({log_addr[0], log_addr[1]}), int'({AW'(a), a1}));
            chk(rd == {hi, lo}, "R6 word read assembly", int'(rd), int'({hi, lo}));
            // Byte write: high half must not reach memory
            bb = 8'(a * 7 + 3);
            keep_next = mem[a1];
            access(1'b1, 1'b0, AW'(a), {8'hEE, bb}, (a + 2) % 4, rd);
            chk(log_addr[0] == AW'(a) && log_we[0] && log_data[0] == bb, "R5 byte write",
                int'(log_data[0]), int'(bb));
            chk(mem[a1] == keep_next, "R5 neighbour untouched", int'(mem[a1]), int'(keep_next));
            // Byte read
            access(1'b0, 1'b0, AW'(a), 16'hFFFF, (a + 3) % 4, rd);
            chk(log_addr[0] == AW'(a) && !log_we[0], "R5 byte read address",
                int'(log_addr[0]), a);
            chk(rd == {8'h00, bb}, "R7 byte read zero-extend", int'(rd), int'({8'h00, bb}));
        end

        // R9: a long stall at the wrap address
        access(1'b1, 1'b1, AW'(255), 16'hA55A, 9, rd);
        chk(log_addr[1] == '0 && log_data[0] == 8'h5A && log_data[1] == 8'hA5,
            "R9 R4 long stall wrap", int'({log_addr[1], log_data[1]}), int'(16'h00A5));

        finish_run();
    end
endmodule